// File: doc/BRIEF.md
# Exhaustive Small-CNF Satisfiability Oracle

This block is a co-processor for a host-side SAT solver. The host loads a small clause set into a fixed number of clause slots. Each slot holds two variable bitmasks: one marks the variables that appear as positive literals and the other marks the variables that appear negated. After a start command the block steps through every assignment of the active variables, one assignment per clock. It tests all loaded clauses against the current assignment in parallel.

The block does not return a model. When the sweep ends it reports one of two results. Either no assignment satisfies the clause set, or the sweep found satisfying assignments, and the block then reports which active variables keep the same value, true or false, in every one of them. Two running accumulators produce this result. One is the AND of all satisfying assignments and the other is their OR. The block does not detect relations between pairs of variables.

Top module: `cnf_oracle`

## Requirements
- R1: A clause write (`wrEn` high) stores `wrPos`, `wrNeg` and `wrValid` into slot `wrIdx` only when `busy` is low. A write while `busy` is high leaves the slot unchanged.
- R2: A `start` pulse while `busy` is low begins a sweep. `busy` is high for exactly 2^A consecutive cycles, starting with the cycle after the start edge, where A is the effective active-variable count. A `start` while `busy` is high is ignored.
- R3: The effective count A is `activeVars` sampled at start, clamped to NUM_VARS. A value of 0 gives a single-assignment sweep (all variables 0).
- R4: Assignment a, with bit i equal to variable i, satisfies slot k when the slot is invalid or when ((pos & a) | (neg & ~a)) is nonzero. It is a satisfying assignment when every slot is satisfied. A valid slot with both masks zero is never satisfied.
- R5: With `done` high, `satFound` is 1 exactly when at least one assignment in the sweep was satisfying.
- R6: With `done` and `satFound` high, `forcedTrue[i]` is 1 exactly when i < A and variable i is 1 in every satisfying assignment.
- R7: With `done` and `satFound` high, `forcedFalse[i]` is 1 exactly when i < A and variable i is 0 in every satisfying assignment.
- R8: When `done` is high and `satFound` is 0 (UNSAT), `forcedTrue` and `forcedFalse` are all zero. They are also zero while `done` is low.
- R9: `done` rises in the cycle `busy` falls. It stays high, with stable results, until the next accepted start. `busy` and `done` are never high together. After reset, `busy`, `done`, `satFound` and both forced outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Clause slot write strobe |
| wrIdx | input | $clog2(NUM_CLAUSES) | Slot to write |
| wrPos | input | NUM_VARS | Positive-literal mask |
| wrNeg | input | NUM_VARS | Negated-literal mask |
| wrValid | input | 1 | Slot takes part in evaluation |
| start | input | 1 | Start a sweep |
| activeVars | input | $clog2(NUM_VARS+1) | Number of low variables to enumerate |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished, results valid |
| satFound | output | 1 | At least one satisfying assignment seen |
| forcedTrue | output | NUM_VARS | Variables true in every satisfying assignment |
| forcedFalse | output | NUM_VARS | Variables false in every satisfying assignment |

## Verification
A counter that skips or repeats an assignment shows up in the length of the `busy` window as soon as the sweep ends. A stuck end compare makes the run hang instead. An accumulator that is not cleared between sweeps, or a clause slot overwritten during a run, gives a wrong `satFound` or wrong forced bits at the next `done`. The bench therefore runs sweeps back to back, with different clause sets, against an independent brute-force model. Because results only appear after a full sweep, small active counts keep every fault visible within a few hundred cycles.

// File: rtl/cnf_oracle_pkg.sv
package cnf_oracle_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } sweepState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrAllow;  // clause storage may be written
    logic clear;    // begin a sweep: reset counter and accumulators
    logic step;     // evaluate current assignment and advance
  } ctrlStrobe_t;

endpackage

// File: rtl/cnf_clause_bank.sv
module cnf_clause_bank #(
  parameter int NUM_VARS    = 8,
  parameter int NUM_CLAUSES = 8,
  localparam int IDX_W      = $clog2(NUM_CLAUSES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrAllow,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [NUM_VARS-1:0] wrPos,
  input  logic [NUM_VARS-1:0] wrNeg,
  input  logic                wrValid,
  input  logic [NUM_VARS-1:0] trialAssign,
  output logic                allSat
);

  logic [NUM_CLAUSES-1:0] slotOk;

  for (genvar k = 0; k < NUM_CLAUSES; k++) begin : g_slot
    logic [NUM_VARS-1:0] posMask;
    logic [NUM_VARS-1:0] negMask;
    logic                slotValid;
    logic                slotWe;

    assign slotWe = wrAllow && wrEn && (wrIdx == IDX_W'(k));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        posMask   <= '0;
        negMask   <= '0;
        slotValid <= 1'b0;
      end else if (slotWe) begin
        posMask   <= wrPos;
        negMask   <= wrNeg;
        slotValid <= wrValid;
      end
    end

    assign slotOk[k] = !slotValid ||
                       (|((posMask & trialAssign) | (negMask & ~trialAssign)));
  end

  assign allSat = &slotOk;

endmodule

// File: rtl/cnf_sweep_ctrl.sv
module cnf_sweep_ctrl
  import cnf_oracle_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        lastHit,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  sweepState_e state;
  sweepState_e stateNext;
  logic        startOk;

  assign startOk = start && (state != ST_RUN);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startOk) stateNext = ST_RUN;
      ST_RUN:  if (lastHit) stateNext = ST_DONE;
      ST_DONE: if (startOk) stateNext = ST_RUN;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strobe.wrAllow = (state != ST_RUN);
  assign strobe.clear   = startOk;
  assign strobe.step    = (state == ST_RUN);
  assign busy           = (state == ST_RUN);
  assign done           = (state == ST_DONE);

endmodule

// File: rtl/cnf_sweep_datapath.sv
module cnf_sweep_datapath
  import cnf_oracle_pkg::*;
#(
  parameter int NUM_VARS    = 8,
  parameter int NUM_CLAUSES = 8,
  localparam int IDX_W      = $clog2(NUM_CLAUSES),
  localparam int ACT_W      = $clog2(NUM_VARS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [NUM_VARS-1:0] wrPos,
  input  logic [NUM_VARS-1:0] wrNeg,
  input  logic                wrValid,
  input  logic [ACT_W-1:0]    activeVars,
  output logic                lastHit,
  output logic                satSeen,
  output logic [NUM_VARS-1:0] andAcc,
  output logic [NUM_VARS-1:0] orAcc,
  output logic [NUM_VARS-1:0] activeMask
);

  logic [NUM_VARS-1:0] trialCnt;
  logic [NUM_VARS-1:0] maskNext;
  logic                allSat;

  cnf_clause_bank #(
    .NUM_VARS   (NUM_VARS),
    .NUM_CLAUSES(NUM_CLAUSES)
  ) u_bank (
    .clk        (clk),
    .rstN       (rstN),
    .wrAllow    (strobe.wrAllow),
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .wrPos      (wrPos),
    .wrNeg      (wrNeg),
    .wrValid    (wrValid),
    .trialAssign(trialCnt),
    .allSat     (allSat)
  );

  // low-A mask; also the last assignment index 2^A-1; A clamps to NUM_VARS
  always_comb begin
    for (int i = 0; i < NUM_VARS; i++) begin
      maskNext[i] = (int'(activeVars) > i);
    end
  end

  assign lastHit = (trialCnt == activeMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialCnt   <= '0;
      activeMask <= '0;
      satSeen    <= 1'b0;
      andAcc     <= '1;
      orAcc      <= '0;
    end else if (strobe.clear) begin
      trialCnt   <= '0;
      activeMask <= maskNext;
      satSeen    <= 1'b0;
      andAcc     <= '1;
      orAcc      <= '0;
    end else if (strobe.step) begin
      if (!lastHit) trialCnt <= trialCnt + 1'b1;
      if (allSat) begin
        satSeen <= 1'b1;
        andAcc  <= andAcc & trialCnt;
        orAcc   <= orAcc | trialCnt;
      end
    end
  end

endmodule

// File: rtl/cnf_oracle.sv
module cnf_oracle
  import cnf_oracle_pkg::*;
#(
  parameter int NUM_VARS    = 8,
  parameter int NUM_CLAUSES = 8,
  localparam int IDX_W      = $clog2(NUM_CLAUSES),
  localparam int ACT_W      = $clog2(NUM_VARS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [NUM_VARS-1:0] wrPos,
  input  logic [NUM_VARS-1:0] wrNeg,
  input  logic                wrValid,
  input  logic                start,
  input  logic [ACT_W-1:0]    activeVars,
  output logic                busy,
  output logic                done,
  output logic                satFound,
  output logic [NUM_VARS-1:0] forcedTrue,
  output logic [NUM_VARS-1:0] forcedFalse
);

  ctrlStrobe_t         strobe;
  logic                lastHit;
  logic                satSeen;
  logic [NUM_VARS-1:0] andAcc;
  logic [NUM_VARS-1:0] orAcc;
  logic [NUM_VARS-1:0] activeMask;
  logic                report;

  cnf_sweep_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .lastHit(lastHit),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  cnf_sweep_datapath #(
    .NUM_VARS   (NUM_VARS),
    .NUM_CLAUSES(NUM_CLAUSES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrEn      (wrEn),
    .wrIdx     (wrIdx),
    .wrPos     (wrPos),
    .wrNeg     (wrNeg),
    .wrValid   (wrValid),
    .activeVars(activeVars),
    .lastHit   (lastHit),
    .satSeen   (satSeen),
    .andAcc    (andAcc),
    .orAcc     (orAcc),
    .activeMask(activeMask)
  );

  assign report      = done && satSeen;
  assign satFound    = done && satSeen;
  assign forcedTrue  = report ? (andAcc & activeMask) : '0;
  assign forcedFalse = report ? (~orAcc & activeMask) : '0;

endmodule

// File: rtl/cnf_oracle_chk.sv
module cnf_oracle_chk #(
  parameter int NUM_VARS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                satFound,
  input logic [NUM_VARS-1:0] forcedTrue,
  input logic [NUM_VARS-1:0] forcedFalse
);

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done)); // R9

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R2

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(satFound) && $stable(forcedTrue) && $stable(forcedFalse))); // R9

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy)); // R9

  AST_UNSAT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (done && !satFound) |-> (forcedTrue == '0 && forcedFalse == '0)); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (forcedTrue == '0 && forcedFalse == '0 && !satFound)); // R8

  AST_NO_BOTH_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    (done && satFound) |-> ((forcedTrue & forcedFalse) == '0)); // R6 R7

endmodule

bind cnf_oracle cnf_oracle_chk #(.NUM_VARS(NUM_VARS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .satFound   (satFound),
  .forcedTrue (forcedTrue),
  .forcedFalse(forcedFalse)
);

// File: tb/cnf_oracle_tb.sv
module cnf_oracle_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrIdx = '0;
  logic [NV-1:0] wrPos = '0;
  logic [NV-1:0] wrNeg = '0;
  logic          wrValid = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    activeVars = '0;
  logic          busy, done, satFound;
  logic [NV-1:0] forcedTrue, forcedFalse;

  int checks = 0;
  int failures = 0;

  // bench shadow of what the clause slots should hold
  logic [NV-1:0] shPos [NC];
  logic [NV-1:0] shNeg [NC];
  logic          shVal [NC];

  // expected results from the brute-force model
  logic          expSat;
  logic [NV-1:0] expT, expF;
  int            busyCycles;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnf_oracle #(.NUM_VARS(NV), .NUM_CLAUSES(NC)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrPos(wrPos),
    .wrNeg(wrNeg), .wrValid(wrValid), .start(start), .activeVars(activeVars),
    .busy(busy), .done(done), .satFound(satFound),
    .forcedTrue(forcedTrue), .forcedFalse(forcedFalse)
  );

  typedef struct packed {
    logic [3:0]    act;
    logic [2:0]    val;
    logic [NV-1:0] p0, n0, p1, n1, p2, n2;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    // v0 forced true, v1 forced false
    '{act: 4'd3, val: 3'b011, p0: 8'h01, n0: 8'h00, p1: 8'h00, n1: 8'h02, p2: 8'h00, n2: 8'h00},
    // v0 and not v0: UNSAT
    '{act: 4'd2, val: 3'b011, p0: 8'h01, n0: 8'h00, p1: 8'h00, n1: 8'h01, p2: 8'h00, n2: 8'h00},
    // xor of v0,v1 plus v2: only v2 forced
    '{act: 4'd4, val: 3'b111, p0: 8'h03, n0: 8'h00, p1: 8'h00, n1: 8'h03, p2: 8'h04, n2: 8'h00},
    // no valid clauses: satisfiable, nothing forced
    '{act: 4'd8, val: 3'b000, p0: 8'h01, n0: 8'h00, p1: 8'h00, n1: 8'h01, p2: 8'h00, n2: 8'h00},
    // clause on inactive v5 (always 0): UNSAT
    '{act: 4'd3, val: 3'b001, p0: 8'h20, n0: 8'h00, p1: 8'h00, n1: 8'h00, p2: 8'h00, n2: 8'h00},
    // implication chain v0 -> v1 -> v2 with v0
    '{act: 4'd5, val: 3'b111, p0: 8'h01, n0: 8'h00, p1: 8'h02, n1: 8'h01, p2: 8'h04, n2: 8'h02}
  };

  function automatic int clampAct(input int a);
    return (a > NV) ? NV : a;
  endfunction

  task automatic computeExpected(input int act);
    int a;
    logic sat;
    logic [NV-1:0] andV, orV, msk;
    a = clampAct(act);
    andV = '1; orV = '0; expSat = 1'b0;
    msk = '0;
    for (int i = 0; i < a; i++) msk[i] = 1'b1;
    for (int v = 0; v < (1 << a); v++) begin
      sat = 1'b1;
      for (int k = 0; k < NC; k++) begin
        if (shVal[k] && ((shPos[k] & NV'(v)) == '0) && ((shNeg[k] & ~NV'(v)) == '0))
          sat = 1'b0;
      end
      if (sat) begin
        expSat = 1'b1;
        andV &= NV'(v);
        orV |= NV'(v);
      end
    end
    expT = expSat ? (andV & msk) : '0;
    expF = expSat ? (~orV & msk) : '0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic writeSlot(input int idx, input logic [NV-1:0] p,
                           input logic [NV-1:0] n, input logic v);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 3'(idx); wrPos = p; wrNeg = n; wrValid = v;
    if (!busy) begin
      shPos[idx] = p; shNeg[idx] = n; shVal[idx] = v;
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // pulse start; count busy cycles at negedges until done
  task automatic runSweep(input int act);
    @(negedge clk);
    start = 1'b1; activeVars = 4'(act);
    @(negedge clk);
    start = 1'b0;
    busyCycles = 0;
    while (!done && busyCycles < 1000) begin
      if (busy) busyCycles++;
      @(negedge clk);
    end
  endtask

  task automatic checkResults(input string tag);
    check(satFound == expSat, "R5", {tag, " satFound"}, satFound, expSat);
    check(forcedTrue == expT, "R6", {tag, " forcedTrue"}, forcedTrue, expT);
    check(forcedFalse == expF, "R7", {tag, " forcedFalse"}, forcedFalse, expF);
    if (!expSat)
      check(forcedTrue == 0 && forcedFalse == 0, "R8", {tag, " unsat zero"},
            {forcedTrue, forcedFalse}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < NC; k++) begin
      shPos[k] = '0; shNeg[k] = '0; shVal[k] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy && !done && !satFound && forcedTrue == 0 && forcedFalse == 0,
          "R9", "reset outputs", {busy, done, satFound, forcedTrue, forcedFalse}, 0);
    rstN = 1'b1;

    // table walk: R4 evaluation rule under several clause sets
    for (int t = 0; t < NVEC; t++) begin
      writeSlot(0, VECS[t].p0, VECS[t].n0, VECS[t].val[0]);
      writeSlot(1, VECS[t].p1, VECS[t].n1, VECS[t].val[1]);
      writeSlot(2, VECS[t].p2, VECS[t].n2, VECS[t].val[2]);
      computeExpected(int'(VECS[t].act));
      runSweep(int'(VECS[t].act));
      check(busyCycles == (1 << int'(VECS[t].act)), "R2", $sformatf("vec%0d busy length", t),
            busyCycles, 1 << int'(VECS[t].act));
      check(done, "R4", $sformatf("vec%0d done", t), done, 1);
      checkResults($sformatf("R4 vec%0d", t));
    end

    // R9: done and results held until next start
    repeat (5) @(negedge clk);
    check(done && !busy, "R9", "done held", {done, busy}, 2'b10);
    checkResults("R9 hold");

    // R3: activeVars 0 gives one assignment
    for (int k = 0; k < NC; k++) writeSlot(k, '0, '0, 1'b0);
    writeSlot(0, 8'h00, 8'h01, 1'b1);   // not v0: satisfied by all-zero
    computeExpected(0);
    runSweep(0);
    check(busyCycles == 1, "R3", "act0 busy length", busyCycles, 1);
    checkResults("R3 act0");

    // R3: activeVars above NUM_VARS clamps to 8 -> 256 cycles
    writeSlot(0, 8'h80, 8'h00, 1'b1);   // v7 forced true
    computeExpected(9);
    runSweep(9);
    check(busyCycles == 256, "R3", "clamp busy length", busyCycles, 256);
    checkResults("R3 clamp");
    check(forcedTrue == 8'h80, "R6", "clamp v7 forced", forcedTrue, 8'h80);

    // R1 + R2: write and start during a run are ignored
    writeSlot(0, '0, '0, 1'b0);
    computeExpected(8);
    @(negedge clk);
    start = 1'b1; activeVars = 4'd8;
    @(negedge clk);
    start = 1'b0;
    busyCycles = 1;                      // this negedge already sees busy
    repeat (3) @(negedge clk);
    busyCycles += 3;
    wrEn = 1'b1; wrIdx = 3'd0; wrPos = '0; wrNeg = '0; wrValid = 1'b1; // empty clause
    start = 1'b1; activeVars = 4'd0;
    @(negedge clk);
    busyCycles++;
    wrEn = 1'b0; start = 1'b0;
    while (!done && busyCycles < 1000) begin
      @(negedge clk);
      if (busy) busyCycles++;
    end
    check(busyCycles == 256, "R2", "start while busy ignored", busyCycles, 256);
    checkResults("R1 write during run");
    // rerun: the ignored write must not have reached slot 0
    runSweep(2);
    computeExpected(2);
    check(satFound == 1'b1, "R1", "slot unchanged after busy write", satFound, 1);
    checkResults("R1 rerun");

    // R4: a valid slot with empty masks is never satisfied
    writeSlot(3, '0, '0, 1'b1);
    computeExpected(4);
    runSweep(4);
    check(!satFound, "R4", "empty clause unsat", satFound, 0);
    checkResults("R8 empty clause");

    // R8: outputs zero while a run is in progress
    @(negedge clk);
    start = 1'b1; activeVars = 4'd4;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done && forcedTrue == 0 && forcedFalse == 0 && !satFound,
          "R8", "zero while busy", {busy, done, forcedTrue, forcedFalse}, 0);
    while (!done) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule